// File: doc/BRIEF.md
# Neuromorphic Core Scan and Sequence Controller

This block sits beside a crossbar neuromorphic core and handles the core's serial data and the order of its operations. Pixel bits for one image come in on two serial lines. Each line feeds its own pixel chain, and the two chains together form the wordline enable vector of the core. After the chains are full, the block asks the core to evaluate and holds the wordlines of the 1-pixels active until the core acknowledges. It then captures the parallel spike vector into an output chain and shifts that chain out one bit per cycle. Only when the last spike bit has left does the block accept the next image.

A separate weight chain is filled serially while the block is idle and in programming mode. Its parallel contents drive the core's programming data. A 3-bit mode field selects erase, program, verify or sensing. In verify mode the block compares a selected column value against a reference and reports pass or fail. The pass rule depends on whether an excitatory or an inhibitory column is selected.

Top module: `nm_seq_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `spike_vld_o`, `eval_req_o` and `verify_o` are 0, `wl_en_o` is all zero and `wgt_word_o` is all zero.
- R2: The mode encodings are 3'b000 idle, 3'b001 erase, 3'b010 program, 3'b011 verify and 3'b100 sense. `start_i` is accepted only while `busy_o` is 0 and the mode is sense. In any other mode it is ignored and `busy_o` stays 0.
- R3: The cycle after an accepted start, the block takes one bit from each `pix_si_i` line on each of 32 consecutive clock edges. Line 0 fills `wl_en_o[31:0]` and line 1 fills `wl_en_o[63:32]`. The first bit taken on a line lands at the highest index of its half.
- R4: `wl_en_o` equals the loaded pixel vector only while `eval_req_o` is 1 and the mode is sense. At all other times it is all zero.
- R5: `eval_req_o` rises right after the 32nd pixel edge and stays high until the edge where `eval_ack_i` is 1. `spike_i` is captured on the next edge.
- R6: After the capture, the spike vector leaves on `spike_so_o` over 64 consecutive cycles, bit 63 first. `spike_vld_o` is high for exactly those cycles.
- R7: `done_o` is high only during the cycle that shows spike bit 0. `busy_o` falls on the following edge. A start asserted while `busy_o` is 1 is ignored.
- R8: The weight chain shifts `wgt_si_i` in at bit 0 on edges where `wgt_shift_i` is 1, the mode is program and `busy_o` is 0. The first bit shifted lands at the top after `WGT_W` shifts. In any other mode, shift requests leave `wgt_word_o` unchanged.
- R9: In verify mode with `exc_sel_i` = 1, `verify_o` on the next edge is 1 exactly when `col_val_i` is greater than `ref_i`.
- R10: In verify mode with `exc_sel_i` = 0, `verify_o` on the next edge is 1 exactly when `col_val_i` is less than `ref_i`. Outside verify mode `verify_o` is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode field |
| exc_sel_i | input | 1 | 1 = excitatory verify, 0 = inhibitory verify |
| start_i | input | 1 | Request to process one image |
| busy_o | output | 1 | An image sequence is in progress |
| done_o | output | 1 | Marks the last spike bit on the serial output |
| pix_si_i | input | 2 | Serial pixel inputs, one per pixel chain |
| wl_en_o | output | 64 | Wordline enables to the core |
| eval_req_o | output | 1 | Evaluation request to the core |
| eval_ack_i | input | 1 | Core reports that spikes are valid |
| spike_i | input | 64 | Parallel spike vector from the core |
| spike_so_o | output | 1 | Serial spike output |
| spike_vld_o | output | 1 | Serial spike output is valid |
| wgt_si_i | input | 1 | Serial weight data |
| wgt_shift_i | input | 1 | Weight chain shift request |
| wgt_word_o | output | 16 | Parallel weight chain contents |
| col_val_i | input | 8 | Selected column value for verify |
| ref_i | input | 8 | Verify reference value |
| verify_o | output | 1 | Verify pass flag |

## Verification
The assertions assume the core raises `eval_ack_i` only while `eval_req_o` is high, holds `spike_i` steady through the capture edge, and leaves the mode at sense for a whole image. The stimulus follows these rules. It changes the mode only while the block is idle and pulses the acknowledge once per image after a chosen delay. It fires stray starts and weight shifts only at moments when the requirements say they must be ignored.

// File: rtl/nm_seq_pkg.sv
`timescale 1ns/1ps
package nm_seq_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE   = 3'b000,
    MODE_ERASE  = 3'b001,
    MODE_PROG   = 3'b010,
    MODE_VERIFY = 3'b011,
    MODE_SENSE  = 3'b100
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_EVAL,
    ST_CAPT,
    ST_SHIFT
  } seq_state_e;
endpackage

// File: rtl/nm_shift_chain.sv
`timescale 1ns/1ps
module nm_shift_chain #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         si_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] q_o,
  output logic         so_o
);
  logic [W-1:0] q_q;

  // load wins over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= load_data_i;
    else if (shift_i) q_q <= {q_q[W-2:0], si_i};
  end

  assign q_o  = q_q;
  assign so_o = q_q[W-1];
endmodule

// File: rtl/nm_seq_fsm.sv
`timescale 1ns/1ps
module nm_seq_fsm
  import nm_seq_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int SPK_W = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] mode_i,
  input  logic       eval_ack_i,
  output seq_state_e state_o,
  output logic       pix_shift_o,
  output logic       spk_load_o,
  output logic       spk_shift_o,
  output logic       last_o
);
  localparam int CNT_MAX = (PIX_W > SPK_W) ? PIX_W : SPK_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] PIX_LAST = CNT_W'(PIX_W - 1);
  localparam logic [CNT_W-1:0] SPK_LAST = CNT_W'(SPK_W - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && mode_i == MODE_SENSE) state_d = ST_LOAD;
      ST_LOAD:  if (cnt_q == PIX_LAST) state_d = ST_EVAL;
      ST_EVAL:  if (eval_ack_i) state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_SHIFT;
      ST_SHIFT: if (cnt_q == SPK_LAST) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q == ST_LOAD || state_q == ST_SHIFT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o     = state_q;
  assign pix_shift_o = (state_q == ST_LOAD);
  assign spk_load_o  = (state_q == ST_CAPT);
  assign spk_shift_o = (state_q == ST_SHIFT);
  assign last_o      = (state_q == ST_SHIFT) && (cnt_q == SPK_LAST);

  p_start_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && mode_i != MODE_SENSE) |=> (state_q == ST_IDLE));
  p_load_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && cnt_q == PIX_LAST) |=> (state_q == ST_EVAL));
  p_eval_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVAL && !eval_ack_i) |=> (state_q == ST_EVAL));
  p_capt_then_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPT) |=> (state_q == ST_SHIFT && cnt_q == '0));
endmodule

// File: rtl/nm_verify_cmp.sv
`timescale 1ns/1ps
module nm_verify_cmp
  import nm_seq_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             exc_sel_i,
  input  logic [VAL_W-1:0] col_val_i,
  input  logic [VAL_W-1:0] ref_i,
  output logic             verify_o
);
  logic pass_q;

  // excitatory passes above ref, inhibitory passes below ref
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else if (mode_i == MODE_VERIFY)
      pass_q <= exc_sel_i ? (col_val_i > ref_i) : (col_val_i < ref_i);
    else pass_q <= 1'b0;
  end

  assign verify_o = pass_q;

  p_exc_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VERIFY && exc_sel_i && col_val_i <= ref_i) |=> !verify_o);
  p_inh_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VERIFY && !exc_sel_i && col_val_i >= ref_i) |=> !verify_o);
  p_no_verify_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_VERIFY) |=> !verify_o);
endmodule

// File: rtl/nm_seq_ctrl.sv
`timescale 1ns/1ps
module nm_seq_ctrl
  import nm_seq_pkg::*;
#(
  parameter int NUM_PIX_CH = 2,
  parameter int PIX_W      = 32,
  parameter int SPK_W      = 64,
  parameter int WGT_W      = 16,
  parameter int VAL_W      = 8,
  localparam int WL_W      = NUM_PIX_CH * PIX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            mode_i,
  input  logic                  exc_sel_i,
  input  logic                  start_i,
  output logic                  busy_o,
  output logic                  done_o,
  input  logic [NUM_PIX_CH-1:0] pix_si_i,
  output logic [WL_W-1:0]       wl_en_o,
  output logic                  eval_req_o,
  input  logic                  eval_ack_i,
  input  logic [SPK_W-1:0]      spike_i,
  output logic                  spike_so_o,
  output logic                  spike_vld_o,
  input  logic                  wgt_si_i,
  input  logic                  wgt_shift_i,
  output logic [WGT_W-1:0]      wgt_word_o,
  input  logic [VAL_W-1:0]      col_val_i,
  input  logic [VAL_W-1:0]      ref_i,
  output logic                  verify_o
);
  seq_state_e      state;
  logic            pix_shift, spk_load, spk_shift, last;
  logic [WL_W-1:0] pix_vec;
  logic [SPK_W-1:0] spk_q;
  logic            spk_so;
  logic            wgt_so;
  logic            wgt_shift_en;

  nm_seq_fsm #(.PIX_W(PIX_W), .SPK_W(SPK_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .eval_ack_i  (eval_ack_i),
    .state_o     (state),
    .pix_shift_o (pix_shift),
    .spk_load_o  (spk_load),
    .spk_shift_o (spk_shift),
    .last_o      (last)
  );

  for (genvar g = 0; g < NUM_PIX_CH; g++) begin : g_pix_ch
    logic so_unused;
    nm_shift_chain #(.W(PIX_W)) u_pix (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .shift_i     (pix_shift),
      .si_i        (pix_si_i[g]),
      .load_i      (1'b0),
      .load_data_i ('0),
      .q_o         (pix_vec[g*PIX_W +: PIX_W]),
      .so_o        (so_unused)
    );
  end

  nm_shift_chain #(.W(SPK_W)) u_spk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (spk_shift),
    .si_i        (1'b0),
    .load_i      (spk_load),
    .load_data_i (spike_i),
    .q_o         (spk_q),
    .so_o        (spk_so)
  );

  assign wgt_shift_en = wgt_shift_i && (mode_i == MODE_PROG) && (state == ST_IDLE);

  nm_shift_chain #(.W(WGT_W)) u_wgt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (wgt_shift_en),
    .si_i        (wgt_si_i),
    .load_i      (1'b0),
    .load_data_i ('0),
    .q_o         (wgt_word_o),
    .so_o        (wgt_so)
  );

  nm_verify_cmp #(.VAL_W(VAL_W)) u_vfy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .exc_sel_i (exc_sel_i),
    .col_val_i (col_val_i),
    .ref_i     (ref_i),
    .verify_o  (verify_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign eval_req_o  = (state == ST_EVAL);
  assign wl_en_o     = (eval_req_o && mode_i == MODE_SENSE) ? pix_vec : '0;
  assign spike_so_o  = spk_so;
  assign spike_vld_o = spk_shift;
  assign done_o      = last;

  p_wl_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_en_o != '0) |-> eval_req_o);
  p_spk_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_vld_o && !done_o) |=> spike_vld_o);
  p_done_vld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spike_vld_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_wgt_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || mode_i != MODE_PROG) |=> $stable(wgt_word_o));
endmodule

// File: tb/nm_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nm_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        exc_sel = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [1:0]  pix_si = '0;
  logic [63:0] wl_en;
  logic        eval_req;
  logic        eval_ack = 1'b0;
  logic [63:0] spike = '0;
  logic        spike_so, spike_vld;
  logic        wgt_si = 1'b0;
  logic        wgt_shift = 1'b0;
  logic [15:0] wgt_word;
  logic [7:0]  col_val = '0;
  logic [7:0]  ref_v = '0;
  logic        verify;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];  // {last, bit}

  always #10 clk = ~clk;

  nm_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .exc_sel_i(exc_sel),
    .start_i(start), .busy_o(busy), .done_o(done), .pix_si_i(pix_si),
    .wl_en_o(wl_en), .eval_req_o(eval_req), .eval_ack_i(eval_ack),
    .spike_i(spike), .spike_so_o(spike_so), .spike_vld_o(spike_vld),
    .wgt_si_i(wgt_si), .wgt_shift_i(wgt_shift), .wgt_word_o(wgt_word),
    .col_val_i(col_val), .ref_i(ref_v), .verify_o(verify)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops expected spike bits as the design shifts them out
  always @(negedge clk) begin
    if (rst_n && spike_vld) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected spike_vld", 64'(spike_vld), 64'h0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk("R6 spike bit", 64'(spike_so), 64'(e[0]));
        chk("R7 done_o", 64'(done), 64'(e[1]));
      end
    end else if (rst_n) begin
      chk("R7 done_o outside shift", 64'(done), 64'h0);
    end
  end

  task automatic run_image(input logic [63:0] p, input logic [63:0] s,
                           input int ack_dly, input bit stray_start);
    @(negedge clk);
    mode  = 3'b100;
    start = 1'b1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      start     = 1'b0;
      pix_si[0] = p[31-k];
      pix_si[1] = p[63-k];
      if (k == 0) chk("R2 busy after start", 64'(busy), 64'h1);
      chk("R4 wl idle during load", wl_en, 64'h0);
    end
    for (int d = 0; d < ack_dly; d++) begin
      @(negedge clk);
      chk("R5 eval_req held", 64'(eval_req), 64'h1);
      chk("R4 wl during eval", wl_en, p);
    end
    @(negedge clk);
    chk("R3 R4 wl pattern", wl_en, p);
    chk("R5 eval_req", 64'(eval_req), 64'h1);
    spike    = s;
    eval_ack = 1'b1;
    for (int j = 63; j >= 0; j--) exp_q.push_back({(j == 0), s[j]});
    @(negedge clk);
    eval_ack = 1'b0;
    chk("R4 wl after ack", wl_en, 64'h0);
    chk("R5 eval_req drop", 64'(eval_req), 64'h0);
    for (int j = 0; j < 64; j++) begin
      @(negedge clk);
      if (j == 0) spike = ~s;  // captured value must not follow
      start = (stray_start && j == 10);
    end
    start = 1'b0;
    @(negedge clk);
    chk("R7 busy falls after done", 64'(busy), 64'h0);
    chk("R6 all bits emitted", 64'(exp_q.size()), 64'h0);
    chk("R6 vld low after shift", 64'(spike_vld), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'h0);
    chk("R1 wl", wl_en, 64'h0);
    chk("R1 outputs", {59'h0, done, spike_vld, eval_req, verify, 1'b0}, 64'h0);
    chk("R1 wgt", 64'(wgt_word), 64'h0);
    rst_n = 1'b1;

    // R2: start in non-sense modes is ignored
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      mode  = 3'(m);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 start ignored", 64'(busy), 64'h0);
    end

    // R8: weight programming
    begin
      logic [15:0] w;
      w = 16'hA5C3;
      @(negedge clk);
      mode = 3'b010;
      for (int k = 0; k < 16; k++) begin
        wgt_si    = w[15-k];
        wgt_shift = 1'b1;
        @(negedge clk);
      end
      wgt_shift = 1'b0;
      chk("R8 weight word", 64'(wgt_word), 64'(w));
      mode      = 3'b100;
      wgt_shift = 1'b1;
      wgt_si    = 1'b1;
      repeat (3) @(negedge clk);
      wgt_shift = 1'b0;
      chk("R8 shift ignored outside program", 64'(wgt_word), 64'(w));
    end

    run_image(64'h8000_0001_F0F0_1234, 64'hDEAD_BEEF_0123_4567, 0, 1'b0);
    run_image(64'h0F0F_AAAA_5555_C001, 64'h8000_0000_0000_0001, 3, 1'b1);
    run_image(64'hFFFF_FFFF_0000_0000, 64'h0, 1, 1'b0);

    // R9 / R10: verify
    @(negedge clk);
    mode = 3'b011; exc_sel = 1'b1; col_val = 8'd10; ref_v = 8'd5;
    @(negedge clk);
    chk("R9 exc above ref", 64'(verify), 64'h1);
    col_val = 8'd5;
    @(negedge clk);
    chk("R9 exc equal ref", 64'(verify), 64'h0);
    exc_sel = 1'b0; col_val = 8'd3;
    @(negedge clk);
    chk("R10 inh below ref", 64'(verify), 64'h1);
    col_val = 8'd7;
    @(negedge clk);
    chk("R10 inh above ref", 64'(verify), 64'h0);
    col_val = 8'd5;
    @(negedge clk);
    chk("R10 inh equal ref", 64'(verify), 64'h0);
    col_val = 8'd1; mode = 3'b100;
    @(negedge clk);
    chk("R10 no verify outside mode", 64'(verify), 64'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule